// File: doc/BRIEF.md
# Cascadable Dual 8b/10b Line Encoder

This block is the line-coding stage of a transmit path. It turns bytes into 10-bit code groups from the standard 8b/10b code, so that the serial stream has enough transitions for clock recovery and stays DC-balanced. Each byte comes with a flag that marks it as a control character. Control characters are the few special groups used for commas and framing.

The block holds two encoder lanes and a width input. In single-width mode only lane 0 works, and one byte becomes one 10-bit group per clock. In double-width mode both lanes work in the same clock. Lane 0 encodes the low byte starting from the registered running disparity. Its ending disparity goes straight into lane 1, which encodes the high byte. The 20-bit result is therefore balanced as one continuous stream. Outputs are registered, with one clock of latency. An input-valid strobe decides whether a clock advances the running disparity.

Top module: `cascade_linecode_enc`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `out_code` and `out_kerr`, and sets the running disparity negative (`out_rd` = 0; 1 means positive).
- R2: With `dbl_mode` = 0 and `in_valid` = 1, the byte on `in_data[7:0]` appears one clock later as a 10-bit group on `out_code[9:0]`, and `out_valid` is 1. In the same cycle `out_code[19:10]` and `out_kerr[1]` are 0.
- R3: Every output group holds 4, 5 or 6 ones. A group with 6 ones follows only a negative running disparity, and a group with 4 ones follows only a positive one. Any unbalanced group inverts the running disparity, and a balanced group leaves it unchanged.
- R4: With `dbl_mode` = 1, the byte on `in_data[7:0]` is encoded into `out_code[9:0]` from the registered disparity. The byte on `in_data[15:8]` is encoded into `out_code[19:10]` from the disparity that lane 0 ends with. `out_rd` then takes the disparity that lane 1 ends with.
- R5: A clock with `in_valid` = 0 gives `out_valid` = 0 on the next clock. In that cycle `out_code`, `out_kerr` and `out_rd` keep their previous values.
- R6: With the control flag set, exactly twelve bytes are accepted as control characters: any byte with low five bits 28 (x = 28, any y), and the bytes 0xF7, 0xFB, 0xFD and 0xFE. For example, 0xBC starting from negative disparity gives `out_code[9:0]` = 10'h17C, and from positive disparity gives 10'h283.
- R7: A byte with its control flag set that is not one of the twelve raises its `out_kerr` bit and is encoded as the data byte with the same value.
- R8: For y = 7, the alternate 4-bit sub-block (0111 or 1000, written f first) is used in three cases: when the disparity after the 6-bit sub-block is negative and x is 17, 18 or 20; when it is positive and x is 11, 13 or 14; and for every accepted control character with y = 7. In all other data cases the primary sub-block is used.
- R9: Byte bits [4:0] form x and bits [7:5] form y. A group is placed with a in bit 0, b to e in bits 1 to 4, i in bit 5, and f, g, h, j in bits 6 to 9. Bit 0 is the first bit sent on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbl_mode | input | 1 | 1 = both lanes cascaded, 0 = lane 0 only |
| in_valid | input | 1 | The bytes on the input are to be encoded this clock |
| in_data | input | 16 | Lane 0 byte in [7:0], lane 1 byte in [15:8] |
| in_ctrl | input | 2 | Control flag per lane |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_code | output | 20 | Lane 0 group in [9:0], lane 1 group in [19:10] |
| out_kerr | output | 2 | Per-lane flag: control was requested for a byte that is not a control character |
| out_rd | output | 1 | Running disparity after the last encoded group (1 = positive) |

## Verification
The assertions check, on every cycle, the properties that need no table: the weight of each group and its sign against the disparity it started from, the disparity chain across the two lanes, the hold of all outputs in idle cycles, the quiet upper lane in single width, and the comma and error-flag cases. Only the bench's reference model can show that each group is the exact table entry, with the correct alternate choice and bit placement. It shows this through an exhaustive sweep of all data bytes, the twelve control characters at both disparities, the alternate cases, invalid control requests, and long random runs that mix widths and idle gaps.

// File: rtl/lenc_pkg.sv
package lenc_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;

  // Reverse a 6-bit sub-block written a-first into wire order (a in bit 0).
  function automatic logic [5:0] wire6(input logic [5:0] v);
    for (int i = 0; i < 6; i++) wire6[i] = v[5-i];
  endfunction

  function automatic logic [3:0] wire4(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wire4[i] = v[3-i];
  endfunction
endpackage

// File: rtl/lenc_kvalid.sv
module lenc_kvalid
  import lenc_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic              is_k28,
  output logic              legal_k
);
  logic [X_W-1:0] x;
  logic [Y_W-1:0] y;
  logic           k_x7;

  assign x       = din[X_W-1:0];
  assign y       = din[BYTE_W-1:X_W];
  assign is_k28  = (x == 5'd28);
  assign k_x7    = (y == 3'd7) &&
                   ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30));
  assign legal_k = is_k28 || k_x7;
endmodule

// File: rtl/lenc_slice.sv
module lenc_slice
  import lenc_pkg::*;
(
  input  logic              lane_on,
  input  logic [BYTE_W-1:0] din,
  input  logic              is_ctrl,
  input  logic              rd_in,
  output logic [CODE_W-1:0] code,
  output logic              rd_out,
  output logic              kerr
);
  logic [X_W-1:0] x;
  logic [Y_W-1:0] y;
  logic           is_k28, legal_k, use_k, k28_sel;
  logic [5:0]     base6, sub6;
  logic [3:0]     base4, sub4;
  logic           bal6, bal4, rd6, alt7, flip6, flip4;

  assign x = din[X_W-1:0];
  assign y = din[BYTE_W-1:X_W];

  lenc_kvalid u_kv (
    .din     (din),
    .is_k28  (is_k28),
    .legal_k (legal_k)
  );

  assign use_k   = is_ctrl && legal_k;
  assign k28_sel = use_k && is_k28;

  // 6-bit sub-block, negative-disparity form, a-first.
  always_comb begin
    case (x)
      5'd0:  base6 = 6'b100111;
      5'd1:  base6 = 6'b011101;
      5'd2:  base6 = 6'b101101;
      5'd3:  base6 = 6'b110001;
      5'd4:  base6 = 6'b110101;
      5'd5:  base6 = 6'b101001;
      5'd6:  base6 = 6'b011001;
      5'd7:  base6 = 6'b111000;
      5'd8:  base6 = 6'b111001;
      5'd9:  base6 = 6'b100101;
      5'd10: base6 = 6'b010101;
      5'd11: base6 = 6'b110100;
      5'd12: base6 = 6'b001101;
      5'd13: base6 = 6'b101100;
      5'd14: base6 = 6'b011100;
      5'd15: base6 = 6'b010111;
      5'd16: base6 = 6'b011011;
      5'd17: base6 = 6'b100011;
      5'd18: base6 = 6'b010011;
      5'd19: base6 = 6'b110010;
      5'd20: base6 = 6'b001011;
      5'd21: base6 = 6'b101010;
      5'd22: base6 = 6'b011010;
      5'd23: base6 = 6'b111010;
      5'd24: base6 = 6'b110011;
      5'd25: base6 = 6'b100110;
      5'd26: base6 = 6'b010110;
      5'd27: base6 = 6'b110110;
      5'd28: base6 = k28_sel ? 6'b001111 : 6'b001110;
      5'd29: base6 = 6'b101110;
      5'd30: base6 = 6'b011110;
      default: base6 = 6'b101011;
    endcase
  end

  assign bal6  = ($countones(base6) == 3);
  assign flip6 = rd_in && (!bal6 || (x == 5'd7));
  assign sub6  = flip6 ? ~base6 : base6;
  assign rd6   = rd_in ^ !bal6;

  // Alternate y=7 form keeps run length at five or below.
  assign alt7 = (y == 3'd7) &&
                (use_k ||
                 (!rd6 && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20))) ||
                 ( rd6 && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14))));

  always_comb begin
    case (y)
      3'd0: base4 = 4'b1011;
      3'd1: base4 = 4'b1001;
      3'd2: base4 = 4'b0101;
      3'd3: base4 = 4'b1100;
      3'd4: base4 = 4'b1101;
      3'd5: base4 = 4'b1010;
      3'd6: base4 = 4'b0110;
      default: base4 = alt7 ? 4'b0111 : 4'b1110;
    endcase
  end

  assign bal4  = ($countones(base4) == 2);
  assign flip4 = (k28_sel && bal4 && (y != 3'd3)) ? !rd6
               : (rd6 && (!bal4 || (y == 3'd3)));
  assign sub4  = flip4 ? ~base4 : base4;

  assign code   = lane_on ? {wire4(sub4), wire6(sub6)} : '0;
  assign rd_out = lane_on ? (rd6 ^ !bal4) : rd_in;
  assign kerr   = lane_on && is_ctrl && !legal_k;
endmodule

// File: rtl/cascade_linecode_enc.sv
module cascade_linecode_enc
  import lenc_pkg::*;
#(
  parameter int LANES = 2
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dbl_mode,
  input  logic                    in_valid,
  input  logic [LANES*BYTE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_ctrl,
  output logic                    out_valid,
  output logic [LANES*CODE_W-1:0] out_code,
  output logic [LANES-1:0]        out_kerr,
  output logic                    out_rd
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int OUT_W  = LANES * CODE_W;

  logic [LANES:0]       rd_chain;
  logic [OUT_W-1:0]     code_d;
  logic [LANES-1:0]     kerr_d;

  assign rd_chain[0] = out_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    assign lane_on = (g == 0) ? 1'b1 : dbl_mode;

    lenc_slice u_slice (
      .lane_on (lane_on),
      .din     (in_data[g*BYTE_W +: BYTE_W]),
      .is_ctrl (in_ctrl[g]),
      .rd_in   (rd_chain[g]),
      .code    (code_d[g*CODE_W +: CODE_W]),
      .rd_out  (rd_chain[g+1]),
      .kerr    (kerr_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_kerr  <= '0;
      out_rd    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code <= code_d;
        out_kerr <= kerr_d;
        out_rd   <= rd_chain[LANES];
      end
    end
  end

  if (DATA_W != LANES * BYTE_W) begin : g_bad_width
    $error("lane width mismatch");
  end
endmodule

// File: rtl/lenc_chk.sv
module lenc_chk
  import lenc_pkg::*;
#(
  parameter int LANES = 2
)(
  input logic                    clk,
  input logic                    rst,
  input logic                    dbl_mode,
  input logic                    in_valid,
  input logic [LANES*BYTE_W-1:0] in_data,
  input logic [LANES-1:0]        in_ctrl,
  input logic                    out_valid,
  input logic [LANES*CODE_W-1:0] out_code,
  input logic [LANES-1:0]        out_kerr,
  input logic                    out_rd
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_rd && (out_kerr == '0) && (out_code == '0)));

  a_r2_upper_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl_mode) |=> ((out_code[2*CODE_W-1:CODE_W] == '0) && !out_kerr[1]));

  a_r3_weight: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (($countones(out_code[CODE_W-1:0]) >= 4) &&
                   ($countones(out_code[CODE_W-1:0]) <= 6)));

  a_r3_sign: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((($countones(out_code[CODE_W-1:0]) != 6) || !$past(out_rd)) &&
                  (($countones(out_code[CODE_W-1:0]) != 4) ||  $past(out_rd))));

  a_r3_single_rd: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl_mode) |=>
      (out_rd == (($countones(out_code[CODE_W-1:0]) == 5) ? $past(out_rd)
                 : ($countones(out_code[CODE_W-1:0]) == 6))));

  a_r4_chain: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl_mode) |=>
      (($countones(out_code[2*CODE_W-1:CODE_W]) != 6) ||
       (($past(out_rd) ^ ($countones(out_code[CODE_W-1:0]) != 5)) == 1'b0)));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_rd) && $stable(out_code) && $stable(out_kerr)));

  a_r6_comma: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctrl[0] && (in_data[BYTE_W-1:0] == 8'hBC)) |=>
      (!out_kerr[0] && ((out_code[CODE_W-1:0] == 10'h17C) || (out_code[CODE_W-1:0] == 10'h283))));

  a_r7_bad_ctrl: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctrl[0] && (in_data[BYTE_W-1:0] == 8'h00)) |=> out_kerr[0]);
endmodule

bind cascade_linecode_enc lenc_chk #(.LANES(LANES)) u_lenc_chk (
  .clk       (clk),
  .rst       (rst),
  .dbl_mode  (dbl_mode),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ctrl   (in_ctrl),
  .out_valid (out_valid),
  .out_code  (out_code),
  .out_kerr  (out_kerr),
  .out_rd    (out_rd)
);

// File: tb/test_cascade_linecode_enc.sv
`timescale 1ns/1ps
module test_cascade_linecode_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbl_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_ctrl = '0;
  logic        out_valid;
  logic [19:0] out_code;
  logic [1:0]  out_kerr;
  logic        out_rd;

  always #2 clk = ~clk;

  cascade_linecode_enc i_cascade_linecode_enc (
    .clk(clk), .rst(rst), .dbl_mode(dbl_mode), .in_valid(in_valid),
    .in_data(in_data), .in_ctrl(in_ctrl), .out_valid(out_valid),
    .out_code(out_code), .out_kerr(out_kerr), .out_rd(out_rd)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Expected state, held in the bench.
  logic        m_rd = 0;
  logic [19:0] m_code = '0;
  logic [1:0]  m_kerr = '0;
  logic        m_valid = 0;

  // Negative-disparity forms, a-first / f-first.
  logic [5:0] t6 [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101,
    6'b101001, 6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
    6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011, 6'b010011,
    6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010, 6'b110011, 6'b100110,
    6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
  logic [3:0] t4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
  logic [7:0] klist [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                             8'hF7, 8'hFB, 8'hFD, 8'hFE};

  function automatic logic [9:0] ref_group(input logic [7:0] b, input logic k,
                                           inout logic rd, output logic kerr);
    int x = b[4:0];
    int y = b[7:5];
    logic kok = (x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30));
    logic kk = k && kok;
    logic [5:0] s6;
    logic [3:0] s4;
    logic alt;
    logic [9:0] g;
    kerr = k && !kok;
    s6 = (kk && x == 28) ? 6'b001111 : t6[x];
    if (rd && ($countones(s6) != 3 || x == 7)) s6 = ~s6;
    if ($countones(s6) != 3) rd = ~rd;
    alt = (y == 7) && (kk || (!rd && (x == 17 || x == 18 || x == 20)) ||
                             (rd && (x == 11 || x == 13 || x == 14)));
    s4 = alt ? 4'b0111 : t4[y];
    if (kk && x == 28 && (y == 1 || y == 2 || y == 5 || y == 6)) begin
      if (!rd) s4 = ~s4;
    end else if (rd && ($countones(s4) != 2 || y == 3)) begin
      s4 = ~s4;
    end
    if ($countones(s4) != 2) rd = ~rd;
    for (int i = 0; i < 6; i++) g[i] = s6[5-i];
    for (int i = 0; i < 4; i++) g[6+i] = s4[3-i];
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic m, input logic [15:0] d,
                       input logic [1:0] c, input string req);
    logic ke0, ke1;
    logic [9:0] g0, g1;
    logic [23:0] act, exp;
    @(negedge clk);
    in_valid = v; dbl_mode = m; in_data = d; in_ctrl = c;
    m_valid = v;
    if (v) begin
      g0 = ref_group(d[7:0], c[0], m_rd, ke0);
      if (m) g1 = ref_group(d[15:8], c[1], m_rd, ke1);
      else begin g1 = '0; ke1 = 1'b0; end
      m_code = {g1, g0};
      m_kerr = {ke1, ke0};
    end
    @(posedge clk); #1;
    act = {out_valid, out_rd, out_kerr, out_code};
    exp = {m_valid, m_rd, m_kerr, m_code};
    check(act === exp, req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_ctrl = 0; in_data = 0; dbl_mode = 0;
    repeat (3) @(posedge clk);
    #1;
    m_rd = 0; m_code = '0; m_kerr = '0; m_valid = 0;
    check({out_valid, out_rd, out_kerr, out_code} === 24'h0, "R1 reset",
          {out_valid, out_rd, out_kerr, out_code}, 24'h0);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R6: comma from negative disparity, literal value.
    drive(1, 0, 16'h00BC, 2'b01, "R6 comma");
    check(out_code[9:0] === 10'h17C, "R6 comma literal", {14'h0, out_code[9:0]}, 24'h17C);
    // R6: comma again from positive disparity.
    drive(1, 0, 16'h00BC, 2'b01, "R6 comma");
    check(out_code[9:0] === 10'h283, "R6 comma literal", {14'h0, out_code[9:0]}, 24'h283);

    // R2, R3, R9: every data byte, single width.
    for (int b = 0; b < 256; b++) drive(1, 0, {8'hA5, b[7:0]}, 2'b00, "R2 R3 R9 sweep");

    // R8: alternate candidates at both disparities.
    for (int r = 0; r < 2; r++)
      foreach (klist[i]) begin
        drive(1, 0, 16'h00F1, 0, "R8 alt"); drive(1, 0, 16'h00F2, 0, "R8 alt");
        drive(1, 0, 16'h00F4, 0, "R8 alt"); drive(1, 0, 16'h00EB, 0, "R8 alt");
        drive(1, 0, 16'h00ED, 0, "R8 alt"); drive(1, 0, 16'h00EE, 0, "R8 alt");
        drive(1, 0, 16'h0000, 0, "R8 alt");
      end

    // R6: all control characters, single and double width.
    for (int r = 0; r < 2; r++)
      foreach (klist[i]) begin
        drive(1, 0, {8'h00, klist[i]}, 2'b01, "R6 R8 control");
        drive(1, 1, {klist[11 - i], klist[i]}, 2'b11, "R6 R4 control");
      end

    // R7: control flag on bytes that are not control characters.
    drive(1, 0, 16'h0000, 2'b01, "R7 bad ctrl");
    drive(1, 0, 16'h001B, 2'b01, "R7 bad ctrl");
    drive(1, 1, 16'h1DF7, 2'b11, "R7 bad ctrl upper");
    drive(1, 1, 16'hFC3F, 2'b11, "R7 bad ctrl lower");

    // R5: idle cycles keep all state.
    drive(1, 0, 16'h0007, 0, "R5 pre");
    drive(0, 0, 16'hFFFF, 2'b11, "R5 idle");
    drive(0, 1, 16'h1234, 2'b00, "R5 idle");

    // R4, R3, R5: random mix.
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r = $urandom;
      logic [15:0] d = r[15:0];
      logic [1:0]  c = r[17:16] & {r[20], r[21]};
      if (c[0] && r[22]) d[7:0] = klist[r[27:24] % 12];
      if (c[1] && r[23]) d[15:8] = klist[r[31:28] % 12];
      drive(r[18] | r[19], r[19] ^ r[25], d, c, "R4 R3 R5 random");
    end

    // R1: reset mid-stream after positive disparity.
    drive(1, 0, 16'h00BC, 2'b01, "R1 pre");
    do_reset();
    drive(1, 1, 16'hBCBC, 2'b11, "R1 R4 after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule